// File: doc/BRIEF.md
# Comma-Aligned Serial Word Deserializer

This block sits behind a clock and data recovery stage. It takes one recovered serial bit per bit-clock cycle into a 10-bit sliding window and compares the window on every cycle against both running-disparity forms of the 8b/10b K28.5 comma. When a comma arrives, the comma becomes the first character of a new frame and sets the 10-bit character boundary. From then on the block emits one aligned 10-bit character every ten bit clocks, together with a valid strobe.

Each emitted character carries a flag that marks a fresh alignment. A separate one-cycle pulse reports any comma in the window at any bit offset. A byte-rate clock enable accompanies the characters. In full-speed operation it fires with every character, which is 1/10 of the bit rate. In half-speed operation it fires with every second character, which is 1/20 of the bit rate. Half-speed operation is selected when both rate-select inputs are low. A comma-detect enable decides whether commas may move the boundary. Comma reporting does not depend on it.

Top module: `sds_comma_aligner`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `word_valid`, `realigned`, `byte_ce`, `comma_seen` and `locked` are 0 and `word_out` is 0.
- R2: The comma codes are 10'h17C and 10'h283. Bit 0 of the window holds the earliest received bit. `comma_seen` is 1 in the cycle that follows the clock edge that shifted in the last bit of either code, at any offset, whatever the value of `comma_en`.
- R3: While unlocked with `comma_en` high, a received comma is output as a character with `word_valid` and `realigned` both 1, and `locked` becomes 1. While unlocked, no other character is output.
- R4: Once locked, `word_valid` pulses for one cycle every 10 bit clocks. In each character, `word_out[0]` is the earliest of its ten bits.
- R5: A comma that lands exactly on the current boundary is output as a normal character with `realigned` at 0.
- R6: A comma at any other offset while locked, with `comma_en` high, is output at once with `realigned` at 1. Later characters are counted from that comma.
- R7: With `comma_en` low, a comma at a new offset neither outputs a character nor moves the boundary, and a lock is not acquired.
- R8: When `rate_sel` or `sync_sel` is 1, `byte_ce` is 1 with every character.
- R9: When `rate_sel` and `sync_sel` are both 0, `byte_ce` is 1 on every second character, and always on a character that starts a new alignment.
- R10: `byte_ce` is never 1 without `word_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata | input | 1 | Recovered serial data bit |
| comma_en | input | 1 | Allows commas to move the character boundary |
| rate_sel | input | 1 | Rate select; both selects low means half-speed |
| sync_sel | input | 1 | Sync select; both selects low means half-speed |
| word_out | output | 10 | Aligned character, bit 0 received first |
| word_valid | output | 1 | One-cycle strobe for a new character |
| comma_seen | output | 1 | A comma completed in the window at any offset |
| realigned | output | 1 | Current character starts a new alignment |
| byte_ce | output | 1 | Byte-rate clock enable |
| locked | output | 1 | A character boundary has been set |

## Verification
On every cycle the assertions check the following. The ten-cycle spacing of characters within an alignment. That a realigned character is always a comma. That `byte_ce` and `word_valid` are never set without their prerequisites. That `comma_seen` agrees with an independent history of the serial input. Other behaviour only shows in the bench scenarios: where the boundary lands after a realignment, that a comma on the boundary does not realign, that `comma_en` low keeps the old boundary, and the alternation of `byte_ce` in half-speed operation, including its restart on a new alignment.

// File: rtl/sds_pkg.sv
package sds_pkg;
    localparam int unsigned CHAR_W = 10;
    typedef logic [CHAR_W-1:0] char_t;
    // Both disparities of the alignment comma, bit 0 received first
    localparam char_t COMMA_NEG = 10'h17C;
    localparam char_t COMMA_POS = 10'h283;
endpackage

// File: rtl/sds_comma_match.sv
module sds_comma_match #(
    parameter int unsigned W     = sds_pkg::CHAR_W,
    parameter logic [W-1:0] PAT_A = sds_pkg::COMMA_NEG,
    parameter logic [W-1:0] PAT_B = sds_pkg::COMMA_POS
) (
    input  logic [W-1:0] win,
    output logic         hit
);
    localparam int unsigned NPAT = 2;
    logic [NPAT-1:0] eq;

    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        localparam logic [W-1:0] PAT = (p == 0) ? PAT_A : PAT_B;
        assign eq[p] = (win == PAT);
    end

    assign hit = |eq;
endmodule

// File: rtl/sds_rate_gen.sv
module sds_rate_gen #(
    parameter int unsigned SLOW_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half,
    input  logic boundary,
    input  logic restart,
    output logic ce
);
    localparam int unsigned SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [SW-1:0] RELOAD = SW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [SW-1:0] skip;
        logic          ce;
    } rg_t;

    rg_t d, q;

    always_comb begin
        d    = q;
        d.ce = 1'b0;
        if (restart) begin
            d.ce   = 1'b1;
            d.skip = half ? RELOAD : '0;
        end else if (boundary) begin
            if (!half || q.skip == '0) begin
                d.ce   = 1'b1;
                d.skip = half ? RELOAD : '0;
            end else begin
                d.skip = q.skip - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ce = q.ce;
endmodule

// File: rtl/sds_comma_aligner.sv
module sds_comma_aligner #(
    parameter int unsigned  W        = sds_pkg::CHAR_W,
    parameter int unsigned  SLOW_DIV = 2,
    parameter logic [W-1:0] COMMA_A  = sds_pkg::COMMA_NEG,
    parameter logic [W-1:0] COMMA_B  = sds_pkg::COMMA_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdata,
    input  logic         comma_en,
    input  logic         rate_sel,
    input  logic         sync_sel,
    output logic [W-1:0] word_out,
    output logic         word_valid,
    output logic         comma_seen,
    output logic         realigned,
    output logic         byte_ce,
    output logic         locked
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  win;
        logic [CW-1:0] cnt;
        logic          locked;
        logic [W-1:0]  word;
        logic          valid;
        logic          seen;
        logic          realign;
    } al_t;

    al_t d, q;

    logic [W-1:0] win_n;
    logic         hit;
    logic         boundary;
    logic         take;
    logic         emit;
    logic         half;

    assign win_n = {sdata, q.win[W-1:1]};

    sds_comma_match #(.W(W), .PAT_A(COMMA_A), .PAT_B(COMMA_B)) u_match (
        .win (win_n),
        .hit (hit)
    );

    assign half = !rate_sel && !sync_sel;

    always_comb begin
        boundary  = q.locked && (q.cnt == LAST);
        take      = hit && comma_en && !boundary;
        emit      = boundary || take;

        d         = q;
        d.win     = win_n;
        d.seen    = hit;
        d.valid   = emit;
        d.realign = take;
        d.locked  = q.locked || take;
        if (emit)          d.cnt = '0;
        else if (q.locked) d.cnt = q.cnt + 1'b1;
        else               d.cnt = '0;
        if (emit) d.word = win_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sds_rate_gen #(.SLOW_DIV(SLOW_DIV)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .half     (half),
        .boundary (boundary),
        .restart  (take),
        .ce       (byte_ce)
    );

    assign word_out   = q.word;
    assign word_valid = q.valid;
    assign comma_seen = q.seen;
    assign realigned  = q.realign;
    assign locked     = q.locked;
endmodule

// File: rtl/sds_comma_aligner_chk.sv
module sds_comma_aligner_chk #(
    parameter int unsigned  W       = sds_pkg::CHAR_W,
    parameter logic [W-1:0] COMMA_A = sds_pkg::COMMA_NEG,
    parameter logic [W-1:0] COMMA_B = sds_pkg::COMMA_POS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sdata,
    input logic         rate_sel,
    input logic         sync_sel,
    input logic [W-1:0] word_out,
    input logic         word_valid,
    input logic         comma_seen,
    input logic         realigned,
    input logic         byte_ce,
    input logic         locked
);
    localparam int unsigned GW = $clog2(W) + 1;

    logic [W-1:0]  hist;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            gap  <= '0;
        end else begin
            hist <= {sdata, hist[W-1:1]};
            if (word_valid)      gap <= '0;
            else if (&gap == 0)  gap <= gap + 1'b1;
        end
    end

    // R2: comma report matches an independent serial history
    p_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        comma_seen == ((hist == COMMA_A) || (hist == COMMA_B)));

    // R3: characters only come out once locked
    p_valid_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> locked);

    // R4: within one alignment, characters are W cycles apart
    p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !realigned) |-> (gap == GW'(W - 1)));

    // R6: a realigned character is always a comma
    p_realign_comma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        realigned |-> (word_valid && (word_out == COMMA_A || word_out == COMMA_B)));

    // R8: full-speed operation enables every character
    p_full_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(rate_sel || sync_sel)) |-> byte_ce);

    // R10: byte enable only with a character
    p_ce_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ce |-> word_valid);
endmodule

bind sds_comma_aligner sds_comma_aligner_chk #(.W(W), .COMMA_A(COMMA_A), .COMMA_B(COMMA_B)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdata      (sdata),
    .rate_sel   (rate_sel),
    .sync_sel   (sync_sel),
    .word_out   (word_out),
    .word_valid (word_valid),
    .comma_seen (comma_seen),
    .realigned  (realigned),
    .byte_ce    (byte_ce),
    .locked     (locked)
);

// File: tb/sds_comma_aligner_test.sv
`timescale 1ns/1ps
module sds_comma_aligner_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b0;
    logic       comma_en = 1'b1;
    logic       rate_sel = 1'b1;
    logic       sync_sel = 1'b0;
    logic [9:0] word_out;
    logic       word_valid, comma_seen, realigned, byte_ce, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] s_word;
    logic       s_valid, s_seen, s_real, s_ce, s_lock;

    always #4 clk = ~clk;

    sds_comma_aligner uut (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .comma_en(comma_en),
        .rate_sel(rate_sel), .sync_sel(sync_sel), .word_out(word_out),
        .word_valid(word_valid), .comma_seen(comma_seen), .realigned(realigned),
        .byte_ce(byte_ce), .locked(locked)
    );

    // {char, expect valid, expect realigned, expect byte_ce}
    localparam int NVEC = 6;
    localparam logic [12:0] VEC [NVEC] = '{
        {10'h2AA, 1'b0, 1'b0, 1'b0},
        {10'h17C, 1'b1, 1'b1, 1'b1},
        {10'h333, 1'b1, 1'b0, 1'b1},
        {10'h283, 1'b1, 1'b0, 1'b1},
        {10'h155, 1'b1, 1'b0, 1'b1},
        {10'h0CC, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic b);
        @(negedge clk);
        sdata = b;
        @(posedge clk);
        #1;
        s_word = word_out; s_valid = word_valid; s_seen = comma_seen;
        s_real = realigned; s_ce = byte_ce; s_lock = locked;
    endtask

    task automatic send_word(input logic [9:0] w, input logic ev, input logic er,
                             input logic eb, input int emid, input string tag);
        int mid = 0;
        for (int i = 0; i < 10; i++) begin
            step(w[i]);
            if (i < 9 && s_valid) mid++;
        end
        check({tag, " mid-character strobes R4"}, mid, emid);
        check({tag, " valid R3/R4"}, s_valid, ev);
        if (ev) begin
            check({tag, " character R4"}, s_word, w);
            check({tag, " realigned R5/R6"}, s_real, er);
            check({tag, " byte_ce R8/R9"}, s_ce, eb);
        end
        check({tag, " comma_seen R2"}, s_seen, (w == 10'h17C || w == 10'h283));
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("reset valid R1", word_valid, 0);
        check("reset locked R1", locked, 0);
        check("reset byte_ce R1", byte_ce, 0);
        check("reset word R1", word_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("post-reset seen/realigned R1", {comma_seen, realigned}, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // table walk: unlocked, initial lock (R3), boundary commas (R5), full rate (R8)
        for (int v = 0; v < NVEC; v++)
            send_word(VEC[v][12:3], VEC[v][2], VEC[v][1], VEC[v][0], 0, "table");

        // R9: half-speed alternation
        rate_sel = 1'b0; sync_sel = 1'b0;
        send_word(10'h2AA, 1, 0, 1, 0, "half R9 a");
        send_word(10'h155, 1, 0, 0, 0, "half R9 b");
        send_word(10'h333, 1, 0, 1, 0, "half R9 c");

        // R6: comma three bits off the boundary, half-speed restart (R9)
        step(0); step(1); step(0);
        send_word(10'h17C, 1, 1, 1, 1, "realign R6");
        send_word(10'h2AA, 1, 0, 0, 0, "after realign R6 R9");
        send_word(10'h155, 1, 0, 1, 0, "after realign R6 b");

        // R8 with only sync_sel high
        sync_sel = 1'b1;
        send_word(10'h333, 1, 0, 1, 0, "sync full R8");

        // R7: comma at new offset with detection off
        comma_en = 1'b0;
        step(0); step(1); step(0);
        send_word(10'h283, 0, 0, 0, 1, "gated R7");
        send_word(10'h2AA, 0, 0, 0, 1, "old boundary kept R7");
        comma_en = 1'b1;
        send_word(10'h17C, 1, 1, 1, 1, "re-enabled R6");
        send_word(10'h155, 1, 0, 1, 0, "after re-enable R6");

        // R7/R3: no lock while unlocked and gated
        do_reset();
        comma_en = 1'b0;
        send_word(10'h17C, 0, 0, 0, 0, "unlocked gated R7");
        check("unlocked gated stays unlocked R7", s_lock, 0);
        comma_en = 1'b1;
        send_word(10'h283, 1, 1, 1, 0, "lock on positive comma R3");
        check("locked after comma R3", s_lock, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule